// File: doc/BRIEF.md
# Shared Dual-Port RAM with CPU Write Priority

This block is a 2 KB true dual-port RAM. One port belongs to a CPU and the other to a DMA engine. The RAM occupies the top 2 KB of the secondary data region. The CPU reaches it with byte addresses, which are decoded against a base parameter. The DMA engine uses a local word offset. Both ports can read or write in every cycle. Neither port ever waits, because the block has no wait or ready signal.

When both ports write the same word in the same cycle, the CPU data is stored and the DMA write is dropped. The DMA side then sees a one-cycle collision flag, so the engine can retry or report the loss. If no DMA traffic is present, the CPU can use the RAM as ordinary scratch storage.

Top module: `dpram_cpu_pri`

## Requirements
- R1: The storage holds 1024 words of 16 bits. The CPU window runs from byte address BASE (default 0xF800) to BASE+2047. The CPU word index is (cpu_addr-BASE)>>1, so bit 0 of the byte address is ignored. The DMA port addresses words through a 10-bit offset.
- R2: A read is an enabled access with the write enable low. Its data appears on that port's read-data output in the cycle after the access, whatever the other port does. When a port makes no read, its read-data output holds its previous value.
- R3: When both ports write the same word in the same cycle, the word holds the CPU write data afterwards.
- R4: dma_collide is high for exactly the one cycle after a same-word write by both ports. It is low after every other cycle, including two writes to different words.
- R5: When the two ports write different words in the same cycle, both words are updated.
- R6: A CPU access outside the window has no effect. A write leaves every word unchanged, and a read returns zero on cpu_rdata in the next cycle.
- R7: A read of a word that the other port writes in the same cycle returns the word's previous contents.
- R8: While rst_n is low, cpu_rdata, dma_rdata and dma_collide are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_en | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, one cycle after the read |
| dma_en | input | 1 | DMA access strobe |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_off | input | 10 | DMA word offset |
| dma_wdata | input | 16 | DMA write data |
| dma_rdata | output | 16 | DMA read data, one cycle after the read |
| dma_collide | output | 1 | DMA write lost to a same-word CPU write |

## Verification
The bench targets same-word double writes. If the design let the DMA win, the word would later read back the DMA data. If it raised the flag on different-word writes, dma_collide would be high where the model expects it low.

Reads that coincide with a write by the other port must return the old contents. A write-first implementation would return the new data instead.

The bench also drives CPU addresses just below the window and at its last word. An off-by-one decode would either corrupt a word or return stored data instead of zero.

Finally, idle cycles follow reads. A read-data output that did not hold would change with no access made.

// File: rtl/dpram_cpu_pri.sv
module dpram_cpu_pri #(
  parameter int DATA_W = 16,
  parameter int CPU_AW = 16,
  parameter int WORDS  = 1024,
  parameter logic [15:0] BASE = 16'hF800
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_en,
  input  logic                      cpu_we,
  input  logic [CPU_AW-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic [DATA_W-1:0]         cpu_rdata,
  input  logic                      dma_en,
  input  logic                      dma_we,
  input  logic [$clog2(WORDS)-1:0]  dma_off,
  input  logic [DATA_W-1:0]         dma_wdata,
  output logic [DATA_W-1:0]         dma_rdata,
  output logic                      dma_collide
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int LSB   = $clog2(DATA_W / 8);
  localparam int TOP   = LSB + IDX_W;

  logic [DATA_W-1:0] mem [WORDS];

  logic [CPU_AW:0]    off;
  logic               cpu_hit;
  logic [IDX_W-1:0]   cidx;
  logic               cpu_wr, cpu_rd, dma_wr, dma_rd, clash;

  assign off     = {1'b0, cpu_addr} - {1'b0, BASE[CPU_AW-1:0]};
  assign cpu_hit = !off[CPU_AW] && (off[CPU_AW-1:TOP] == '0);
  assign cidx    = off[TOP-1:LSB];
  assign cpu_wr  = cpu_en && cpu_we && cpu_hit;
  assign cpu_rd  = cpu_en && !cpu_we;
  assign dma_wr  = dma_en && dma_we;
  assign dma_rd  = dma_en && !dma_we;
  assign clash   = cpu_wr && dma_wr && (cidx == dma_off);

  always_ff @(posedge clk) begin
    if (dma_wr && !clash) mem[dma_off] <= dma_wdata;
    if (cpu_wr)           mem[cidx]    <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata   <= '0;
      dma_rdata   <= '0;
      dma_collide <= 1'b0;
    end else begin
      if (cpu_rd) cpu_rdata <= cpu_hit ? mem[cidx] : '0;
      if (dma_rd) dma_rdata <= mem[dma_off];
      dma_collide <= clash;
    end
  end

  AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clash) |-> mem[$past(dma_off)] == $past(cpu_wdata)); // R3

  AST_BOTH_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_wr && dma_wr && !clash) |->
      (mem[$past(cidx)] == $past(cpu_wdata)) && (mem[$past(dma_off)] == $past(dma_wdata))); // R5

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_collide |-> $past(cpu_en && cpu_we && dma_en && dma_we)); // R4

  AST_OOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_en && !cpu_we && !cpu_hit) |-> cpu_rdata == '0); // R6

  AST_DMA_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dma_rd) |-> $stable(dma_rdata)); // R2
endmodule

// File: tb/dpram_cpu_pri_bench.sv
`timescale 1ns/1ps
module dpram_cpu_pri_bench;
  localparam int BASE = 'hF800;
  logic clk = 0, rst_n = 0;
  logic cpu_en = 0, cpu_we = 0, dma_en = 0, dma_we = 0;
  logic [15:0] cpu_addr = 0, cpu_wdata = 0, dma_wdata = 0;
  logic [9:0]  dma_off = 0;
  logic [15:0] cpu_rdata, dma_rdata;
  logic        dma_collide;

  always #2 clk = ~clk;

  dpram_cpu_pri u_dpram_cpu_pri (.*);

  int ref_mem [1024];
  int exp_cr = 0, exp_dr = 0, exp_col = 0;
  int checks = 0, failures = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit ce, bit cw, int ca, int cd, bit de, bit dw, int da, int dd, string tag);
    bit hit; int ci, col;
    cpu_en = ce; cpu_we = cw; cpu_addr = ca[15:0]; cpu_wdata = cd[15:0];
    dma_en = de; dma_we = dw; dma_off = da[9:0]; dma_wdata = dd[15:0];
    hit = (ca >= BASE) && (ca <= BASE + 2047);
    ci  = (ca - BASE) / 2;
    if (ce && !cw) exp_cr = hit ? ref_mem[ci] : 0;
    if (de && !dw) exp_dr = ref_mem[da];
    col = (ce && cw && hit && de && dw && ci == da) ? 1 : 0;
    exp_col = col;
    if (de && dw && !col) ref_mem[da] = dd & 'hFFFF;
    if (ce && cw && hit) ref_mem[ci] = cd & 'hFFFF;
    @(posedge clk); @(negedge clk);
    chk({"R2/R6/R7 cpu_rdata ", tag}, cpu_rdata, exp_cr);
    chk({"R2/R7 dma_rdata ", tag}, dma_rdata, exp_dr);
    chk({"R4 dma_collide ", tag}, dma_collide, exp_col);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 cpu_rdata in reset", cpu_rdata, 0);
    chk("R8 dma_rdata in reset", dma_rdata, 0);
    chk("R8 dma_collide in reset", dma_collide, 0);
    rst_n = 1;
    // R1: fill every word through the CPU window
    for (int i = 0; i < 1024; i++) step(1,1,BASE+2*i,i*7+3, 0,0,0,0, "fill");
    // R1/R2: read back across the window via both ports, odd byte address
    for (int i = 0; i < 1024; i += 37) step(1,0,BASE+2*i+1,0, 1,0,i,0, "R1 readback");
    // R3/R4: same-word double write, then confirm CPU data landed
    step(1,1,BASE+2*5,'hC0DE, 1,1,5,'hD0AA, "R3 clash");
    step(1,0,BASE+2*5,0, 1,0,5,0, "R3 readback");
    // R4/R5: different words written together, no flag
    step(1,1,BASE+2*6,'h1111, 1,1,7,'h2222, "R5 split");
    step(1,0,BASE+2*7,0, 1,0,6,0, "R5 readback");
    // R7: read while other port writes same word
    step(1,1,BASE+2*9,'hAAAA, 1,0,9,0, "R7 dma reads old");
    step(1,0,BASE+2*10,0, 1,1,10,'hBBBB, "R7 cpu reads old");
    step(1,0,BASE+2*10,0, 0,0,0,0, "R7 new value");
    // R6: just below window, and last word in window
    step(1,1,BASE-2,'hDEAD, 0,0,0,0, "R6 oow write");
    step(1,0,BASE-2,0, 1,0,1023,0, "R6 oow read");
    step(1,1,BASE-2,'hBEEF, 1,1,1023,'h5A5A, "R6 oow vs dma");
    step(1,0,BASE+2047,0, 1,0,0,0, "R1 last word");
    // R2: idle cycles hold outputs
    step(0,0,0,0, 0,0,0,0, "R2 hold");
    step(0,1,BASE,'h7777, 0,1,0,'h8888, "R2 disabled write");
    step(1,0,BASE,0, 1,0,0,0, "R2 after disabled");
    // mixed traffic on a few hot words
    for (int n = 0; n < 3000; n++) begin
      int k, ca;
      k = $urandom_range(0, 9);
      ca = (k == 9) ? BASE - 2*$urandom_range(1,4) : BASE + 2*$urandom_range(0,7);
      step($urandom_range(0,3) != 0, $urandom_range(0,1), ca, $urandom_range(0,65535),
           $urandom_range(0,3) != 0, $urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,65535),
           "mixed");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule